// File: doc/BRIEF.md
# Banked Stack Pointer and Mode Controller

This block keeps the two stack pointers of a 32-bit processor core, one for the main (kernel and handler) stack and one for the process (application) stack. It also keeps a two-bit control register and tracks two states: whether the core runs in thread or handler mode, and whether it is at the privileged or the user level. Only one stack pointer is active at a time. Handler mode always uses the main pointer. In thread mode, control bit 1 picks the pointer.

The surrounding core sends the block register read and write requests, single-word push and pop requests, and exception entry and return events. The block answers with the active stack pointer, a registered memory address and access kind for every stack access, read data for register reads, and a one-cycle fault pulse for any access the current level does not allow. Exception entry stores an automatic frame on the pointer that was active before the switch into handler mode. Exception return removes the frame from the pointer that the restored mode selects. A small nesting store remembers the mode that was interrupted, so that nested exceptions unwind in the correct order.

Top module: `stack_bank_ctrl`

## Requirements
- R1: After reset the block is in thread mode at the privileged level. Both control bits are 0, both stack pointers are 0, `mem_kind` is 0 (none), and `fault` is 0.
- R2: Bits 1:0 of both stack pointers are always 0. A value written to a pointer has these two bits cleared.
- R3: A push lowers the active pointer by 4. In the next cycle `mem_kind` is 1 (push write) and `mem_addr` is the new pointer value.
- R4: A pop gives `mem_addr` equal to the active pointer from before the pop, with `mem_kind` 2 (pop read), and raises the pointer by 4.
- R5: In handler mode, `sp_cur` is the main pointer. In thread mode it is the process pointer when control bit 1 is 1, and the main pointer when it is 0.
- R6: Control bit 1 takes a written value only in thread mode at the privileged level. In handler mode the bit keeps its value, and a write that asks for a different value raises `fault`.
- R7: Control bit 0 takes a written value only at the privileged level. While it is 1, thread mode runs at the user level (`privileged` 0).
- R8: Exception entry switches to handler mode at the privileged level. It lowers the pointer that was active before entry by FRAME_WORDS*4. `mem_addr` gives the new value of that pointer, with `mem_kind` 3 (frame store).
- R9: Exception return restores the mode that was active at the matching entry, with nesting. `mem_addr` gives the pointer that the restored mode selects, with `mem_kind` 4 (frame load), and that pointer then rises by FRAME_WORDS*4.
- R10: At the user level, any read or write with `reg_sel` 0 (main), 1 (process) or 2 (control) is ignored and raises `fault`, and a read returns 0. `reg_sel` 3 (active pointer) is allowed at every level.
- R11: `fault` is a pulse lasting one cycle, one cycle after the faulting request. Exception return with no open exception, and exception entry with NEST_DEPTH exceptions already open, are ignored and raise `fault`.
- R12: Only one request is served per cycle. The priority is entry, then return, then push, then pop, then register write, then register read.
- R13: A register read gives `reg_rdata` in the next cycle, and `reg_rdata` keeps that value until the next read. Control reads as {30 zeros, bit 1, bit 0}, with bit 1 read as 0 in handler mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_sel | input | 2 | 0 main pointer, 1 process pointer, 2 control, 3 active pointer |
| reg_wdata | input | AW | Write data |
| push_req | input | 1 | Push one word |
| pop_req | input | 1 | Pop one word |
| exc_enter | input | 1 | Exception entry event |
| exc_leave | input | 1 | Exception return event |
| sp_cur | output | AW | Active stack pointer |
| reg_rdata | output | AW | Register read data |
| mem_addr | output | AW | Address of the last stack access |
| mem_kind | output | 3 | 0 none, 1 push write, 2 pop read, 3 frame store, 4 frame load |
| handler_mode | output | 1 | 1 in handler mode |
| privileged | output | 1 | 1 at the privileged level |
| ctrl_q | output | 2 | Stored control bits |
| fault | output | 1 | Illegal access pulse |

## Verification
A directed run moves through the mode changes in order. Privileged thread stack work on the main pointer comes first. A switch to the process pointer follows, then an entry that must store its frame on the process pointer, then handler-mode control writes that tell a locked bit apart from a writable one. Next come a return into user thread and blocked register accesses. The run ends with corner cases: return with no open exception, nesting past its limit, and requests made together, which test the priority order. Constrained random traffic then mixes all requests at random levels and pointer values, with occasional requests made together. This shows whether pointer selection, the frame arithmetic and fault decisions still agree with a model in the bench across long nested sequences.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_ENTER = 3'd1,
    OP_LEAVE = 3'd2,
    OP_PUSH  = 3'd3,
    OP_POP   = 3'd4,
    OP_WR    = 3'd5,
    OP_RD    = 3'd6
  } op_e;

  localparam logic [2:0] MK_NONE    = 3'd0;
  localparam logic [2:0] MK_PUSH    = 3'd1;
  localparam logic [2:0] MK_POP     = 3'd2;
  localparam logic [2:0] MK_STACK   = 3'd3;
  localparam logic [2:0] MK_UNSTACK = 3'd4;

  localparam logic [1:0] SEL_MAIN   = 2'd0;
  localparam logic [1:0] SEL_PROC   = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_ACTIVE = 2'd3;

  // Fixed service order: entry, return, push, pop, write, read
  function automatic op_e pick_op(input logic en, input logic lv,
                                  input logic pu, input logic po,
                                  input logic wr, input logic rd);
    if (en)      return OP_ENTER;
    else if (lv) return OP_LEAVE;
    else if (pu) return OP_PUSH;
    else if (po) return OP_POP;
    else if (wr) return OP_WR;
    else if (rd) return OP_RD;
    else         return OP_IDLE;
  endfunction

endpackage

// File: rtl/sbc_sp_bank.sv
module sbc_sp_bank #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic          upd_idx,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] sp_main,
  output logic [AW-1:0] sp_proc
);
  localparam int NBANK = 2;

  logic [NBANK-1:0][AW-1:0] bank;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [AW-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (upd_en && (upd_idx == 1'(g))) begin
        val_q <= {upd_val[AW-1:2], 2'b00};
      end
    end
    assign bank[g] = val_q;
  end

  assign sp_main = bank[0];
  assign sp_proc = bank[1];
endmodule

// File: rtl/sbc_mode_ctrl.sv
module sbc_mode_ctrl
  import sbc_pkg::*;
#(
  parameter int NEST_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  op_e        op,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_wd,
  output logic       handler_q,
  output logic [1:0] ctrl_q,
  output logic       enter_ok,
  output logic       leave_ok,
  output logic       ret_handler
);
  localparam int CW = $clog2(NEST_DEPTH + 1);

  logic [NEST_DEPTH-1:0] saved_q;
  logic [CW-1:0]         depth_q;
  logic [CW-1:0]         top_idx;

  assign enter_ok = (depth_q != CW'(NEST_DEPTH));
  assign leave_ok = (depth_q != '0);
  assign top_idx  = depth_q - CW'(1);

  always_comb begin
    ret_handler = 1'b0;
    for (int i = 0; i < NEST_DEPTH; i++) begin
      if (leave_ok && (CW'(i) == top_idx)) ret_handler = saved_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q   <= '0;
      depth_q   <= '0;
      handler_q <= 1'b0;
      ctrl_q    <= 2'b00;
    end else begin
      if (op == OP_ENTER && enter_ok) begin
        for (int i = 0; i < NEST_DEPTH; i++) begin
          if (CW'(i) == depth_q) saved_q[i] <= handler_q;
        end
        depth_q   <= depth_q + CW'(1);
        handler_q <= 1'b1;
      end else if (op == OP_LEAVE && leave_ok) begin
        depth_q   <= top_idx;
        handler_q <= ret_handler;
      end
      if (ctrl_we) begin
        ctrl_q[0] <= ctrl_wd[0];
        if (!handler_q) ctrl_q[1] <= ctrl_wd[1];
      end
    end
  end
endmodule

// File: rtl/sbc_out_reg.sv
module sbc_out_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nxt_mem_en,
  input  logic [AW-1:0] nxt_addr,
  input  logic [2:0]    nxt_kind,
  input  logic          nxt_rd_en,
  input  logic [AW-1:0] nxt_rdata,
  input  logic          nxt_fault,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_kind,
  output logic [AW-1:0] reg_rdata,
  output logic          fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_kind  <= 3'd0;
      reg_rdata <= '0;
      fault     <= 1'b0;
    end else begin
      mem_kind <= nxt_mem_en ? nxt_kind : 3'd0;
      if (nxt_mem_en) mem_addr  <= nxt_addr;
      if (nxt_rd_en)  reg_rdata <= nxt_rdata;
      fault <= nxt_fault;
    end
  end
endmodule

// File: rtl/stack_bank_ctrl.sv
module stack_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int FRAME_WORDS = 8,
  parameter int NEST_DEPTH  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          exc_enter,
  input  logic          exc_leave,
  output logic [AW-1:0] sp_cur,
  output logic [AW-1:0] reg_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_kind,
  output logic          handler_mode,
  output logic          privileged,
  output logic [1:0]    ctrl_q,
  output logic          fault
);
  localparam logic [AW-1:0] WORD_B  = AW'(4);
  localparam logic [AW-1:0] FRAME_B = AW'(FRAME_WORDS * 4);

  op_e           op;
  logic          handler_q;
  logic [1:0]    ctrl_r;
  logic          enter_ok, leave_ok, ret_handler;
  logic [AW-1:0] sp_main, sp_proc;
  logic          idx_now, idx_ret;
  logic [AW-1:0] sp_now, sp_ret;
  logic          priv;
  logic          sel_guarded, acc_block, ctrl_we, lock_fault;

  logic          upd_en, upd_idx;
  logic [AW-1:0] upd_val;
  logic          nxt_mem_en, nxt_rd_en, nxt_fault;
  logic [AW-1:0] nxt_addr, nxt_rdata;
  logic [2:0]    nxt_kind;

  assign op = pick_op(exc_enter, exc_leave, push_req, pop_req, reg_wr, reg_rd);

  // Pointer selection before and after a return (R5, R9)
  assign idx_now = !handler_q && ctrl_r[1];
  assign idx_ret = !ret_handler && ctrl_r[1];
  assign sp_now  = idx_now ? sp_proc : sp_main;
  assign sp_ret  = idx_ret ? sp_proc : sp_main;
  assign priv    = handler_q || !ctrl_r[0];

  assign sel_guarded = (reg_sel != SEL_ACTIVE);
  assign acc_block   = ((op == OP_WR) || (op == OP_RD)) && sel_guarded && !priv;
  assign ctrl_we     = (op == OP_WR) && (reg_sel == SEL_CTRL) && priv;
  assign lock_fault  = ctrl_we && handler_q && (reg_wdata[1] != ctrl_r[1]);

  always_comb begin
    upd_en     = 1'b0;
    upd_idx    = idx_now;
    upd_val    = sp_now;
    nxt_mem_en = 1'b0;
    nxt_kind   = MK_NONE;
    nxt_addr   = sp_now;
    nxt_rd_en  = 1'b0;
    nxt_rdata  = '0;
    nxt_fault  = acc_block || lock_fault;
    case (op)
      OP_ENTER: begin
        if (enter_ok) begin
          upd_en     = 1'b1;
          upd_val    = sp_now - FRAME_B;
          nxt_mem_en = 1'b1;
          nxt_kind   = MK_STACK;
          nxt_addr   = sp_now - FRAME_B;
        end else begin
          nxt_fault = 1'b1;
        end
      end
      OP_LEAVE: begin
        if (leave_ok) begin
          upd_en     = 1'b1;
          upd_idx    = idx_ret;
          upd_val    = sp_ret + FRAME_B;
          nxt_mem_en = 1'b1;
          nxt_kind   = MK_UNSTACK;
          nxt_addr   = sp_ret;
        end else begin
          nxt_fault = 1'b1;
        end
      end
      OP_PUSH: begin
        upd_en     = 1'b1;
        upd_val    = sp_now - WORD_B;
        nxt_mem_en = 1'b1;
        nxt_kind   = MK_PUSH;
        nxt_addr   = sp_now - WORD_B;
      end
      OP_POP: begin
        upd_en     = 1'b1;
        upd_val    = sp_now + WORD_B;
        nxt_mem_en = 1'b1;
        nxt_kind   = MK_POP;
        nxt_addr   = sp_now;
      end
      OP_WR: begin
        if (!acc_block) begin
          case (reg_sel)
            SEL_MAIN:   begin upd_en = 1'b1; upd_idx = 1'b0; upd_val = reg_wdata; end
            SEL_PROC:   begin upd_en = 1'b1; upd_idx = 1'b1; upd_val = reg_wdata; end
            SEL_ACTIVE: begin upd_en = 1'b1; upd_val = reg_wdata; end
            default:    upd_en = 1'b0;
          endcase
        end
      end
      OP_RD: begin
        nxt_rd_en = 1'b1;
        if (!acc_block) begin
          case (reg_sel)
            SEL_MAIN:   nxt_rdata = sp_main;
            SEL_PROC:   nxt_rdata = sp_proc;
            SEL_CTRL:   nxt_rdata = {{(AW-2){1'b0}}, ctrl_r[1] && !handler_q, ctrl_r[0]};
            default:    nxt_rdata = sp_now;
          endcase
        end
      end
      default: ;
    endcase
  end

  sbc_mode_ctrl #(.NEST_DEPTH(NEST_DEPTH)) mode_i (
    .clk(clk), .rst(rst), .op(op), .ctrl_we(ctrl_we), .ctrl_wd(reg_wdata[1:0]),
    .handler_q(handler_q), .ctrl_q(ctrl_r), .enter_ok(enter_ok),
    .leave_ok(leave_ok), .ret_handler(ret_handler)
  );

  sbc_sp_bank #(.AW(AW)) bank_i (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_idx(upd_idx), .upd_val(upd_val),
    .sp_main(sp_main), .sp_proc(sp_proc)
  );

  sbc_out_reg #(.AW(AW)) out_i (
    .clk(clk), .rst(rst), .nxt_mem_en(nxt_mem_en), .nxt_addr(nxt_addr),
    .nxt_kind(nxt_kind), .nxt_rd_en(nxt_rd_en), .nxt_rdata(nxt_rdata),
    .nxt_fault(nxt_fault), .mem_addr(mem_addr), .mem_kind(mem_kind),
    .reg_rdata(reg_rdata), .fault(fault)
  );

  assign sp_cur       = sp_now;
  assign handler_mode = handler_q;
  assign privileged   = priv;
  assign ctrl_q       = ctrl_r;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_sel,
  input logic [AW-1:0] reg_wdata,
  input logic          push_req,
  input logic          pop_req,
  input logic          exc_enter,
  input logic          exc_leave,
  input logic [AW-1:0] sp_cur,
  input logic [AW-1:0] reg_rdata,
  input logic [AW-1:0] mem_addr,
  input logic [2:0]    mem_kind,
  input logic          handler_mode,
  input logic          privileged,
  input logic [1:0]    ctrl_q,
  input logic          fault
);
  assert_word_align_R2: assert property (@(posedge clk) disable iff (rst)
    (sp_cur[1:0] == 2'b00) && (mem_addr[1:0] == 2'b00));

  assert_push_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (push_req && !exc_enter && !exc_leave) |=> (mem_kind == 3'd1 && mem_addr == sp_cur));

  assert_pop_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !exc_enter && !exc_leave)
      |=> (mem_kind == 3'd2 && mem_addr + AW'(4) == sp_cur));

  assert_handler_bit1_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (handler_mode && $past(handler_mode)) |-> (ctrl_q[1] == $past(ctrl_q[1])));

  assert_user_bit0_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(privileged) |-> (ctrl_q[0] == $past(ctrl_q[0])));

  assert_entry_priv_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(handler_mode) |-> (privileged && mem_kind == 3'd3));

  assert_return_unstack_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(handler_mode) |-> (mem_kind == 3'd4));

  assert_user_block_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel != 2'd3 && !privileged && !exc_enter && !exc_leave
      && !push_req && !pop_req) |=> fault);
endmodule

bind stack_bank_ctrl sbc_checker #(.AW(AW)) chk_i (.*);

// File: tb/stack_bank_ctrl_tb_top.sv
module stack_bank_ctrl_tb_top;
  localparam int CLK_P  = 10;
  localparam int AW     = 32;
  localparam int FRAME  = 8;
  localparam int NEST   = 8;
  localparam int NRAND  = 3000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 0, reg_rd = 0, push_req = 0, pop_req = 0;
  logic          exc_enter = 0, exc_leave = 0;
  logic [1:0]    reg_sel = 0;
  logic [AW-1:0] reg_wdata = 0;
  logic [AW-1:0] sp_cur, reg_rdata, mem_addr;
  logic [2:0]    mem_kind;
  logic          handler_mode, privileged, fault;
  logic [1:0]    ctrl_q;

  int total = 0;
  int bad   = 0;

  // bench model state
  logic [AW-1:0] m_sp [2];
  logic          m_h;
  logic [1:0]    m_ctrl;
  logic          m_saved [NEST];
  int            m_depth;
  logic [AW-1:0] m_addr, m_rdata;
  logic [2:0]    m_kind;
  logic          m_fault;

  always #(CLK_P/2) clk = ~clk;

  stack_bank_ctrl #(.AW(AW), .FRAME_WORDS(FRAME), .NEST_DEPTH(NEST)) dut_i (.*);

  function automatic logic m_priv();
    return m_h || !m_ctrl[0];
  endfunction

  function automatic int m_idx(input logic h);
    return (!h && m_ctrl[1]) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "sp_cur",   sp_cur,            m_sp[m_idx(m_h)]);
    chk(tag, "mem_kind", AW'(mem_kind),     AW'(m_kind));
    chk(tag, "mem_addr", mem_addr,          m_addr);
    chk(tag, "rdata",    reg_rdata,         m_rdata);
    chk(tag, "fault",    AW'(fault),        AW'(m_fault));
    chk(tag, "handler",  AW'(handler_mode), AW'(m_h));
    chk(tag, "priv",     AW'(privileged),   AW'(m_priv()));
    chk(tag, "ctrl",     AW'(ctrl_q),       AW'(m_ctrl));
  endtask

  task automatic model(input logic en, lv, pu, po, wr, rd, input logic [1:0] sel,
                       input logic [AW-1:0] wd);
    int  i  = m_idx(m_h);
    logic pv = m_priv();
    m_kind  = 3'd0;
    m_fault = 1'b0;
    if (en) begin
      if (m_depth == NEST) m_fault = 1'b1;
      else begin
        m_saved[m_depth] = m_h;
        m_depth++;
        m_sp[i] = m_sp[i] - AW'(FRAME*4);
        m_addr  = m_sp[i];
        m_kind  = 3'd3;
        m_h     = 1'b1;
      end
    end else if (lv) begin
      if (m_depth == 0) m_fault = 1'b1;
      else begin
        m_depth--;
        m_h = m_saved[m_depth];
        i   = m_idx(m_h);
        m_addr  = m_sp[i];
        m_sp[i] = m_sp[i] + AW'(FRAME*4);
        m_kind  = 3'd4;
      end
    end else if (pu) begin
      m_sp[i] = m_sp[i] - AW'(4);
      m_addr  = m_sp[i];
      m_kind  = 3'd1;
    end else if (po) begin
      m_addr  = m_sp[i];
      m_sp[i] = m_sp[i] + AW'(4);
      m_kind  = 3'd2;
    end else if (wr) begin
      if (sel != 2'd3 && !pv) m_fault = 1'b1;
      else if (sel == 2'd3) m_sp[i] = {wd[AW-1:2], 2'b00};
      else if (sel == 2'd0) m_sp[0] = {wd[AW-1:2], 2'b00};
      else if (sel == 2'd1) m_sp[1] = {wd[AW-1:2], 2'b00};
      else begin
        m_ctrl[0] = wd[0];
        if (!m_h) m_ctrl[1] = wd[1];
        else if (wd[1] != m_ctrl[1]) m_fault = 1'b1;
      end
    end else if (rd) begin
      if (sel != 2'd3 && !pv) begin m_fault = 1'b1; m_rdata = '0; end
      else if (sel == 2'd3) m_rdata = m_sp[i];
      else if (sel == 2'd0) m_rdata = m_sp[0];
      else if (sel == 2'd1) m_rdata = m_sp[1];
      else m_rdata = {{(AW-2){1'b0}}, m_ctrl[1] && !m_h, m_ctrl[0]};
    end
  endtask

  // called at a falling edge; result sampled at the following falling edge
  task automatic step(input string tag, input logic en, lv, pu, po, wr, rd,
                      input logic [1:0] sel, input logic [AW-1:0] wd);
    exc_enter = en; exc_leave = lv; push_req = pu; pop_req = po;
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    model(en, lv, pu, po, wr, rd, sel, wd);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rand_step();
    int r = int'($urandom % 100);
    logic en = r < 6, lv = (r >= 6 && r < 13), pu = (r >= 13 && r < 35);
    logic po = (r >= 35 && r < 55), wr = (r >= 55 && r < 77), rd = (r >= 77 && r < 95);
    logic [1:0] sel = 2'($urandom);
    string tg;
    if ($urandom % 20 == 0) begin pu = 1'b1; po = 1'b1; wr = 1'b1; end
    if (en) tg = "R8"; else if (lv) tg = "R9"; else if (pu) tg = "R3";
    else if (po) tg = "R4"; else if (wr) tg = (sel == 2'd2) ? "R6" : "R10";
    else if (rd) tg = "R13"; else tg = "R5";
    step(tg, en, lv, pu, po, wr, rd, sel, $urandom);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_sp[0] = '0; m_sp[1] = '0; m_h = 0; m_ctrl = 0; m_depth = 0;
    m_addr = '0; m_rdata = '0; m_kind = 0; m_fault = 0;
    for (int k = 0; k < NEST; k++) m_saved[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");

    // privileged thread, main pointer
    step("R2",  0,0,0,0,1,0, 2'd0, 32'h2000_8003);
    step("R3",  0,0,1,0,0,0, 2'd0, 0);
    step("R3",  0,0,1,0,0,0, 2'd0, 0);
    step("R4",  0,0,0,1,0,0, 2'd0, 0);
    step("R13", 0,0,0,0,0,1, 2'd3, 0);
    // move thread to the process pointer
    step("R2",  0,0,0,0,1,0, 2'd1, 32'h2000_4002);
    step("R5",  0,0,0,0,1,0, 2'd2, 32'h2);
    step("R5",  0,0,1,0,0,0, 2'd0, 0);
    step("R13", 0,0,0,0,0,1, 2'd2, 0);
    // entry stacks on the process pointer, handler then on main
    step("R8",  1,0,0,0,0,0, 2'd0, 0);
    step("R5",  0,0,1,0,0,0, 2'd0, 0);
    step("R13", 0,0,0,0,0,1, 2'd2, 0);
    step("R6",  0,0,0,0,1,0, 2'd2, 32'h0);
    step("R7",  0,0,0,0,1,0, 2'd2, 32'h3);
    step("R8",  1,0,0,0,0,0, 2'd0, 0);
    step("R9",  0,1,0,0,0,0, 2'd0, 0);
    step("R5",  0,0,0,1,0,0, 2'd0, 0);
    step("R9",  0,1,0,0,0,0, 2'd0, 0);
    // user thread now
    step("R7",  0,0,0,0,0,0, 2'd0, 0);
    step("R10", 0,0,0,0,0,1, 2'd0, 0);
    step("R10", 0,0,0,0,1,0, 2'd1, 32'h1234_5678);
    step("R10", 0,0,0,0,1,0, 2'd2, 32'h0);
    step("R10", 0,0,0,0,1,0, 2'd3, 32'h2000_6000);
    step("R11", 0,1,0,0,0,0, 2'd0, 0);
    step("R11", 0,0,0,0,0,0, 2'd0, 0);
    step("R12", 1,1,1,1,1,1, 2'd3, 32'h0);
    step("R12", 0,1,1,1,1,0, 2'd0, 0);
    step("R12", 0,0,1,1,1,1, 2'd3, 32'h4);
    step("R12", 0,0,0,1,1,1, 2'd3, 32'h100);
    // nest past the limit
    for (int k = 0; k < NEST + 1; k++) step("R11", 1,0,0,0,0,0, 2'd0, 0);
    for (int k = 0; k < NEST + 1; k++) step("R9", 0,1,0,0,0,0, 2'd0, 0);
    // back to privileged thread through a handler
    step("R8",  1,0,0,0,0,0, 2'd0, 0);
    step("R7",  0,0,0,0,1,0, 2'd2, {30'd0, m_ctrl[1], 1'b0});
    step("R9",  0,1,0,0,0,0, 2'd0, 0);

    for (int k = 0; k < NRAND; k++) rand_step();

    exc_enter = 0; exc_leave = 0; push_req = 0; pop_req = 0; reg_wr = 0; reg_rd = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule